// File: doc/BRIEF.md
# Timer Event Flag and Interrupt Enable Unit

This block holds the sticky event flags of a timer subsystem together with their interrupt enables, and presents both as two byte-wide registers on a microcontroller's memory-mapped bus. Four output compare channels and three input capture channels each pulse a single-cycle strobe when their event occurs. A shared eighth channel carries either a fourth input capture or a fifth output compare event. A mode input, taken from a separate control register, chooses which of the two it is.

Each strobe latches a flag that stays set until software clears it by writing a 1 to its bit position. Software can poll the flags, or set the matching enable bits and wait for the single interrupt request line. That line is high while any flag is both pending and enabled.

The enable register sits at offset 0x22 and the flag register at offset 0x23 of the register block. Both registers share one bit layout, so that an enable bit sits directly above the flag it gates.

Top module: `tmr_evt_irq_unit`

## Requirements
- R1: After reset the enable register and the flag register both read 0x00, and `irq` is 0.
- R2: In both registers bits 7, 6, 5 and 4 belong to output compare channels 1, 2, 3 and 4 (`oc_evt[0]` to `oc_evt[3]`). Bits 2, 1 and 0 belong to input capture channels 1, 2 and 3 (`ic_evt[0]` to `ic_evt[2]`). A strobe sets its flag on the next clock edge, and the flag then stays set.
- R3: Bit 3 is set by `ic4_evt` when `cap4_sel` is 1 and by `oc5_evt` when `cap4_sel` is 0. A strobe on the channel that is not selected leaves bit 3 unchanged.
- R4: A bus write to offset 0x23 clears every flag whose data bit is 1. Flags under data bits that are 0 keep their value.
- R5: When a strobe and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R6: The enable register at offset 0x22 is fully read/write: a write stores all 8 bits, and reading it returns them. Reading offset 0x23 returns the current flags.
- R7: `irq` is registered and equals the OR of (flags AND enables) as they stand after each clock edge. It therefore changes on the same edge as the flag or enable update that causes it, and it stays high until every enabled pending flag is cleared or disabled.
- R8: A write to any offset other than 0x22 or 0x23 changes neither register, and a read of such an offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Register offset within the block |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| oc_evt | input | 4 | Output compare 1..4 event strobes |
| ic_evt | input | 3 | Input capture 1..3 event strobes |
| ic4_evt | input | 1 | Input capture 4 event strobe |
| oc5_evt | input | 1 | Output compare 5 event strobe |
| cap4_sel | input | 1 | 1 selects input capture 4 for bit 3, 0 selects output compare 5 |
| irq | output | 1 | Interrupt request |

## Verification
A wrong flag bit shows up on `bus_rdata` at offset 0x23 on the cycle after the edge that corrupted it. If the bit is enabled, it also shows on `irq` at that same edge. A fault in the bit 3 source selection, or in the priority between set and clear, only shows up when a strobe lands in a particular mode or cycle, so the bench drives every source in both modes and makes the two collide on purpose. Enable faults are exposed by sweeping all 256 enable values against fixed flag patterns and comparing `irq` after the single edge each write takes.

// File: rtl/tfm_pkg.sv
package tfm_pkg;

    localparam int REG_W = 8;
    localparam int N_OC  = 4;
    localparam int N_IC  = 3;

    // bit positions shared by flag and enable registers
    localparam int OC_TOP_BIT = 7;   // OC1 at 7, OC2 at 6, ...
    localparam int SHARED_BIT = 3;
    localparam int IC_TOP_BIT = 2;   // IC1 at 2, IC2 at 1, IC3 at 0

    typedef logic [REG_W-1:0] reg_t;

    typedef struct packed {
        reg_t enab;
        reg_t flag;
        logic irq;
    } tfm_state_t;

endpackage

// File: rtl/tfm_evt_route.sv
module tfm_evt_route
    import tfm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_OC-1:0] oc_evt,
    input  logic [N_IC-1:0] ic_evt,
    input  logic            ic4_evt,
    input  logic            oc5_evt,
    input  logic            cap4_sel,
    output reg_t            set_vec
);

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < N_OC; i++) begin
            set_vec[OC_TOP_BIT-i] = oc_evt[i];
        end
        for (int j = 0; j < N_IC; j++) begin
            set_vec[IC_TOP_BIT-j] = ic_evt[j];
        end
        set_vec[SHARED_BIT] = cap4_sel ? ic4_evt : oc5_evt;
    end

    // R3: the unselected source of the shared bit never requests a set
    a_r3_oc5_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cap4_sel && !ic4_evt) |-> !set_vec[SHARED_BIT]);
    a_r3_ic4_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap4_sel && !oc5_evt) |-> !set_vec[SHARED_BIT]);

endmodule

// File: rtl/tfm_regs.sv
module tfm_regs
    import tfm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_enab,
    input  logic wr_flag,
    input  reg_t wdata,
    input  reg_t set_vec,
    output reg_t enab_o,
    output reg_t flag_o,
    output logic irq_o
);

    tfm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_enab) begin
            st_d.enab = wdata;
        end
        if (wr_flag) begin
            st_d.flag = st_q.flag & ~wdata;
        end
        // new events take priority over a clear in the same cycle
        st_d.flag = st_d.flag | set_vec;
        st_d.irq  = |(st_d.flag & st_d.enab);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enab_o = st_q.enab;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.irq;

    // R2: a flag only rises after a strobe for that bit
    a_r2_set_only_by_event: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.flag & ~$past(st_q.flag) & ~$past(set_vec)) == '0));
    // R4: zero data bits never clear a flag
    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flag |=> (($past(st_q.flag) & ~$past(wdata) & ~st_q.flag) == '0));
    // R5: a strobe always lands, even against a clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((st_q.flag & $past(set_vec)) == $past(set_vec)));
    // R6: the enable register takes the whole written byte
    a_r6_enab_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enab |=> (st_q.enab == $past(wdata)));
    // R7: request line matches pending enabled flags
    a_r7_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(flag_o & enab_o));

endmodule

// File: rtl/tfm_rdmux.sv
module tfm_rdmux
    import tfm_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] ENAB_OFS = 8'h22,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 8'h23
) (
    input  logic [ADDR_W-1:0] addr,
    input  reg_t              enab,
    input  reg_t              flag,
    output reg_t              rdata
);

    always_comb begin
        rdata = '0;
        if (addr == ENAB_OFS) begin
            rdata = enab;
        end else if (addr == FLAG_OFS) begin
            rdata = flag;
        end
    end

endmodule

// File: rtl/tmr_evt_irq_unit.sv
module tmr_evt_irq_unit
    import tfm_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] ENAB_OFS = 8'h22,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 8'h23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [3:0]        oc_evt,
    input  logic [2:0]        ic_evt,
    input  logic              ic4_evt,
    input  logic              oc5_evt,
    input  logic              cap4_sel,
    output logic              irq
);

    reg_t set_vec;
    reg_t enab_q;
    reg_t flag_q;
    logic wr_enab;
    logic wr_flag;

    assign wr_enab = bus_wr && (bus_addr == ENAB_OFS);
    assign wr_flag = bus_wr && (bus_addr == FLAG_OFS);

    tfm_evt_route u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .oc_evt   (oc_evt),
        .ic_evt   (ic_evt),
        .ic4_evt  (ic4_evt),
        .oc5_evt  (oc5_evt),
        .cap4_sel (cap4_sel),
        .set_vec  (set_vec)
    );

    tfm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_enab (wr_enab),
        .wr_flag (wr_flag),
        .wdata   (bus_wdata),
        .set_vec (set_vec),
        .enab_o  (enab_q),
        .flag_o  (flag_q),
        .irq_o   (irq)
    );

    tfm_rdmux #(
        .ADDR_W   (ADDR_W),
        .ENAB_OFS (ENAB_OFS),
        .FLAG_OFS (FLAG_OFS)
    ) u_rdmux (
        .addr  (bus_addr),
        .enab  (enab_q),
        .flag  (flag_q),
        .rdata (bus_rdata)
    );

    // R8: writes elsewhere leave both registers untouched
    a_r8_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wr_enab && !wr_flag && set_vec == '0)
        |=> ($stable(enab_q) && $stable(flag_q)));
    // R1: reset clears everything
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_zero: assert (enab_q == '0 && flag_q == '0 && !irq);
        end
    end

endmodule

// File: tb/sim_tmr_evt_irq_unit.sv
module sim_tmr_evt_irq_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] oc_evt = 4'h0;
    logic [2:0] ic_evt = 3'h0;
    logic       ic4_evt = 1'b0;
    logic       oc5_evt = 1'b0;
    logic       cap4_sel = 1'b0;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [7:0] ENAB_A = 8'h22;
    localparam logic [7:0] FLAG_A = 8'h23;

    always #5 clk = ~clk;

    tmr_evt_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .oc_evt(oc_evt),
        .ic_evt(ic_evt), .ic4_evt(ic4_evt), .oc5_evt(oc5_evt),
        .cap4_sel(cap4_sel), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    // drive strobes for a register-bit pattern under the current mode
    task automatic drive_pat(input logic [7:0] p, input bit other_too);
        for (int i = 0; i < 4; i++) oc_evt[i] = p[7-i];
        for (int j = 0; j < 3; j++) ic_evt[j] = p[2-j];
        ic4_evt = cap4_sel ? p[3] : other_too;
        oc5_evt = cap4_sel ? other_too : p[3];
    endtask

    task automatic clear_strobes();
        oc_evt = '0; ic_evt = '0; ic4_evt = 1'b0; oc5_evt = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] p, input bit other_too);
        @(negedge clk);
        drive_pat(p, other_too);
        @(negedge clk);
        clear_strobes();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rd(ENAB_A, d); check(d == 8'h00, "R1 enable reset", d, 0);
        rd(FLAG_A, d); check(d == 8'h00, "R1 flag reset", d, 0);
        check(irq == 1'b0, "R1 irq reset", irq, 0);
        rst_n = 1'b1;

        // R2/R3: every source alone, both modes, with the other bit-3 source pulsing
        for (int m = 0; m < 2; m++) begin
            cap4_sel = m[0];
            for (int b = 0; b < 8; b++) begin
                wr(FLAG_A, 8'hFF);
                pulse(8'h01 << b, 1'b0);
                rd(FLAG_A, d);
                check(d == (8'h01 << b), "R2 single source sets its bit", d, 8'h01 << b);
                pulse(8'h00, 1'b0);
                rd(FLAG_A, d);
                check(d == (8'h01 << b), "R2 flag sticky", d, 8'h01 << b);
            end
            wr(FLAG_A, 8'hFF);
            pulse(8'h00, 1'b1);
            rd(FLAG_A, d);
            check(d == 8'h00, "R3 unselected bit-3 source ignored", d, 0);
        end
        cap4_sel = 1'b0;

        // R6: enable register read/write sweep
        for (int v = 0; v < 256; v++) begin
            wr(ENAB_A, v[7:0]);
            rd(ENAB_A, d);
            check(d == v[7:0], "R6 enable readback", d, v);
        end

        // R7: irq against all enables for fixed flag patterns
        for (int k = 0; k < 3; k++) begin
            logic [7:0] p;
            p = (k == 0) ? 8'hA5 : (k == 1) ? 8'h5A : 8'h00;
            wr(FLAG_A, 8'hFF);
            pulse(p, 1'b0);
            for (int v = 0; v < 256; v++) begin
                wr(ENAB_A, v[7:0]);
                check(irq == |(p & v[7:0]), "R7 irq equals OR of flag and enable", irq, |(p & v[7:0]));
            end
        end

        // R7: irq follows a strobe on the same edge as the flag
        wr(ENAB_A, 8'h10);
        wr(FLAG_A, 8'hFF);
        check(irq == 1'b0, "R7 irq low with no flag", irq, 0);
        @(negedge clk); oc_evt[3] = 1'b1;
        @(negedge clk); oc_evt[3] = 1'b0;
        check(irq == 1'b1, "R7 irq rises with flag", irq, 1);
        wr(FLAG_A, 8'hEF);
        check(irq == 1'b1, "R7 irq held while flag pending", irq, 1);
        wr(FLAG_A, 8'h10);
        check(irq == 1'b0, "R7 irq drops on clear", irq, 0);

        // R4: clear sweep with all flags set
        for (int c = 0; c < 256; c++) begin
            pulse(8'hFF, 1'b0);
            wr(FLAG_A, c[7:0]);
            rd(FLAG_A, d);
            check(d == ~c[7:0], "R4 write-1 clears, write-0 keeps", d, ~c[7:0]);
        end

        // R5: set against clear in one cycle, both modes for bit 3
        for (int m = 0; m < 2; m++) begin
            cap4_sel = m[0];
            pulse(8'hFF, 1'b0);
            @(negedge clk);
            bus_addr = FLAG_A; bus_wdata = 8'hFF; bus_wr = 1'b1;
            drive_pat(8'h48, 1'b0);
            @(negedge clk);
            bus_wr = 1'b0; clear_strobes();
            rd(FLAG_A, d);
            check(d == 8'h48, "R5 set wins over clear", d, 8'h48);
        end

        // R8: stray writes and reads
        wr(ENAB_A, 8'h3C);
        wr(FLAG_A, 8'hFF);
        pulse(8'h81, 1'b0);
        for (int a = 0; a < 256; a++) begin
            if (a[7:0] != ENAB_A && a[7:0] != FLAG_A) begin
                wr(a[7:0], 8'hFF);
                rd(a[7:0], d);
                check(d == 8'h00, "R8 other offset reads zero", d, 0);
            end
        end
        rd(ENAB_A, d); check(d == 8'h3C, "R8 enable untouched", d, 8'h3C);
        rd(FLAG_A, d); check(d == 8'h81, "R8 flags untouched", d, 8'h81);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule